// File: doc/BRIEF.md
# Inbound Address Translation Windows

This block sits on the inbound side of a PCI host bridge. When a device on the bus masters a memory cycle, the bridge presents the PCI address on the lookup port. The block decides whether one of its translation windows claims that address. If one does, it returns the 64-bit local memory address the cycle should target. If none does, the address passes through untranslated.

Software sets up the windows through a small 32-bit register port. Each window holds a 64-bit size/enable word and a 64-bit local base. Bit 0 of the size word enables the window. Bits 63:3 of the size word form a mask, and the window covers PCI addresses from zero up to 2^64 minus that mask, minus one. The direct bus-memory decode outranks every window: when the bridge reports that the direct mapping already decodes the address, no window claims it.

The lookup path is purely combinational from the lookup inputs and the stored registers. A register write therefore changes the lookup result from the clock edge that captures it.

Top module: `inbound_xlate_win`

## Requirements
- R1: After reset, every size word reads as 0xFFFFFFFF00000000 and every local base reads as zero, so no window claims any address and every lookup passes through.
- R2: A window whose size-word bit 0 is clear claims no address, whatever its other bits hold.
- R3: Let M be the size word with bits 2:0 forced to zero. An enabled window claims exactly the PCI addresses A with A < 2^64 - M. An M of zero therefore claims every address, and bits 2:0 other than the enable have no effect on the range.
- R4: For a claimed address A, loc_addr equals the window's local base plus A, modulo 2^64.
- R5: When several enabled windows claim the same address, win_idx reports the lowest-numbered of them, and its base is the one used.
- R6: While lk_direct is high, no window claims: win_hit is 0, pass_thru is 1, and loc_addr equals lk_addr.
- R7: pass_thru is the inverse of win_hit. When nothing claims, loc_addr equals lk_addr and win_idx is 0.
- R8: Registers are word-addressed on cfg_addr[5:2]. Window w occupies byte offsets 16*w to 16*w+15:
  - +0x0 holds size bits 31:0.
  - +0x4 holds size bits 63:32.
  - +0x8 holds base bits 31:0.
  - +0xC holds base bits 63:32.

  Reads return the stored half. A write to one half leaves the other half unchanged.
- R9: Window 1 has a 32-bit size register only. A write to offset 0x10 loads the written value into size bits 31:0 and clears bits 63:32. Writes to offset 0x14 are ignored, and reads of 0x14 return the current bits 63:32.
- R10: Offsets 0x30 to 0x3F are not mapped. Reads of them return zero, and writes to them change no register and no lookup result.
- R11: A register write takes effect on lookups in the same cycle the write's clock edge occurs. It is visible at the outputs before the next edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_wr | input | 1 | Register write strobe |
| cfg_addr | input | 6 | Register byte offset |
| cfg_wdata | input | 32 | Register write data |
| cfg_rdata | output | 32 | Register read data for cfg_addr (combinational) |
| lk_addr | input | 64 | PCI address to translate |
| lk_direct | input | 1 | Direct bus-memory mapping decodes lk_addr |
| win_hit | output | 1 | A window claims lk_addr |
| win_idx | output | 2 | Index of the claiming window |
| loc_addr | output | 64 | Translated local address, or lk_addr when passed through |
| pass_thru | output | 1 | No window claims lk_addr |

## Verification
The bench builds the block with its default parameters:
- three windows;
- a 6-bit offset;
- only window 1 narrow;
- the all-ones-high reset size.

These defaults reach every corner in scope. They cover the narrow window's cleared high half and read-only high offset, and the unmapped fourth slot. They also cover three-way overlap for the priority rule, a zero mask that spans the whole 64-bit space, and base-plus-offset wraparound at the top of memory. Directed sequences hit each of these. A random phase then mixes power-of-two and arbitrary masks with lookups near zero, near window edges and across the full address range.

// File: rtl/inbound_xlate_win.sv
module inbound_xlate_win #(
  parameter int              NWIN      = 3,
  parameter logic [NWIN-1:0] WIDE_SIZE = 3'b101,
  parameter logic [63:0]     SIZE_RST  = 64'hFFFF_FFFF_0000_0000,
  parameter int              OFS_W     = 6,
  localparam int             IDX_W     = (NWIN > 1) ? $clog2(NWIN) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cfg_wr,
  input  logic [OFS_W-1:0] cfg_addr,
  input  logic [31:0]      cfg_wdata,
  output logic [31:0]      cfg_rdata,
  input  logic [63:0]      lk_addr,
  input  logic             lk_direct,
  output logic             win_hit,
  output logic [IDX_W-1:0] win_idx,
  output logic [63:0]      loc_addr,
  output logic             pass_thru
);

  localparam int SEL_W = OFS_W - 4;

  logic [63:0]      sz   [NWIN];
  logic [63:0]      base [NWIN];
  logic [NWIN-1:0]  claim;
  logic [IDX_W-1:0] pick;
  logic             any;
  logic [SEL_W-1:0] slot;
  logic [1:0]       fld;

  assign slot = cfg_addr[OFS_W-1:4];
  assign fld  = cfg_addr[3:2];

  for (genvar w = 0; w < NWIN; w++) begin : g_win
    logic [63:0] sz_q, base_q;
    logic [64:0] reach;
    logic        wsel;

    assign wsel = cfg_wr && (slot == SEL_W'(w));

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        sz_q   <= SIZE_RST;
        base_q <= '0;
      end else if (wsel) begin
        case (fld)
          2'd0: begin
            if (WIDE_SIZE[w]) sz_q[31:0] <= cfg_wdata;
            else              sz_q       <= {32'h0, cfg_wdata};
          end
          2'd1: begin
            if (WIDE_SIZE[w]) sz_q[63:32] <= cfg_wdata;
          end
          2'd2:    base_q[31:0]  <= cfg_wdata;
          default: base_q[63:32] <= cfg_wdata;
        endcase
      end
    end

    assign reach    = {1'b0, lk_addr} + {1'b0, sz_q[63:3], 3'b000};
    assign claim[w] = sz_q[0] && !reach[64];
    assign sz[w]    = sz_q;
    assign base[w]  = base_q;

    if (!WIDE_SIZE[w]) begin : g_narrow
      // R9
      narrow_lo_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wsel && fld == 2'd0) |=> (sz_q[63:32] == 32'h0));
      // R9
      narrow_hi_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wsel && fld == 2'd1) |=> $stable(sz_q));
    end
  end

  always_comb begin
    pick = '0;
    any  = 1'b0;
    for (int w = NWIN - 1; w >= 0; w--) begin
      if (claim[w]) begin
        pick = IDX_W'(w);
        any  = 1'b1;
      end
    end
  end

  assign win_hit   = any && !lk_direct;
  assign pass_thru = !win_hit;
  assign win_idx   = win_hit ? pick : '0;
  assign loc_addr  = win_hit ? (base[pick] + lk_addr) : lk_addr;

  always_comb begin
    cfg_rdata = '0;
    for (int w = 0; w < NWIN; w++) begin
      if (slot == SEL_W'(w)) begin
        case (fld)
          2'd0:    cfg_rdata = sz[w][31:0];
          2'd1:    cfg_rdata = sz[w][63:32];
          2'd2:    cfg_rdata = base[w][31:0];
          default: cfg_rdata = base[w][63:32];
        endcase
      end
    end
  end

  logic [NWIN-1:0] lower_m;
  assign lower_m = NWIN'((32'd1 << win_idx) - 32'd1);

  // R6
  direct_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
    lk_direct |-> (pass_thru && !win_hit && loc_addr == lk_addr));
  // R7
  hit_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
    win_hit != pass_thru);
  // R7
  pass_addr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pass_thru |-> (loc_addr == lk_addr && win_idx == '0));
  // R5
  lowest_win_chk: assert property (@(posedge clk) disable iff (!rst_n)
    win_hit |-> (claim[win_idx] && (claim & lower_m) == '0));
  // R10
  unmapped_rd_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (32'(slot) >= NWIN) |-> (cfg_rdata == 32'h0));

endmodule

// File: tb/inbound_xlate_win_tb_top.sv
module inbound_xlate_win_tb_top;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        cfg_wr;
  logic [5:0]  cfg_addr;
  logic [31:0] cfg_wdata;
  logic [31:0] cfg_rdata;
  logic [63:0] lk_addr;
  logic        lk_direct;
  logic        win_hit;
  logic [1:0]  win_idx;
  logic [63:0] loc_addr;
  logic        pass_thru;

  int n_chk = 0;
  int n_err = 0;
  bit chk_on = 0;
  bit done = 0;

  always #10 clk = ~clk;

  inbound_xlate_win dut_i (
    .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_addr(cfg_addr),
    .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata), .lk_addr(lk_addr),
    .lk_direct(lk_direct), .win_hit(win_hit), .win_idx(win_idx),
    .loc_addr(loc_addr), .pass_thru(pass_thru)
  );

  logic [63:0] m_sz [3];
  logic [63:0] m_base [3];

  initial begin
    for (int i = 0; i < 3; i++) begin
      m_sz[i] = 64'hFFFF_FFFF_0000_0000;
      m_base[i] = 64'h0;
    end
  end

  always @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < 3; i++) begin
        m_sz[i] = 64'hFFFF_FFFF_0000_0000;
        m_base[i] = 64'h0;
      end
    end else if (cfg_wr) begin
      int w, f;
      w = int'(cfg_addr) / 16;
      f = (int'(cfg_addr) % 16) / 4;
      if (w < 3) begin
        case (f)
          0: if (w == 1) m_sz[1] = {32'h0, cfg_wdata}; else m_sz[w][31:0] = cfg_wdata;
          1: if (w != 1) m_sz[w][63:32] = cfg_wdata;
          2: m_base[w][31:0] = cfg_wdata;
          default: m_base[w][63:32] = cfg_wdata;
        endcase
      end
    end
  end

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (chk_on && rst_n) begin
      bit h;
      int idx;
      logic [63:0] loc;
      logic [31:0] rd;
      int w, f;
      h = 0; idx = 0; loc = lk_addr;
      if (!lk_direct) begin
        for (int i = 0; i < 3; i++) begin
          if (!h && m_sz[i][0]) begin
            logic [63:0] msk;
            bit c;
            msk = m_sz[i] & ~64'h7;
            c = (msk == 64'h0) ? 1'b1 : (lk_addr < (~msk + 64'd1));
            if (c) begin
              h = 1; idx = i; loc = m_base[i] + lk_addr;
            end
          end
        end
      end
      w = int'(cfg_addr) / 16;
      f = (int'(cfg_addr) % 16) / 4;
      rd = 32'h0;
      if (w < 3) begin
        case (f)
          0: rd = m_sz[w][31:0];
          1: rd = m_sz[w][63:32];
          2: rd = m_base[w][31:0];
          default: rd = m_base[w][63:32];
        endcase
      end
      chk("R7 hit", 64'(win_hit), 64'(h));
      chk("R7 pass_thru", 64'(pass_thru), 64'(!h));
      chk("R5 win_idx", 64'(win_idx), 64'(idx));
      chk("R4 loc_addr", loc_addr, loc);
      chk("R8 rdata", 64'(cfg_rdata), 64'(rd));
    end
  end

  task automatic finish_run;
    if (!done) begin
      done = 1;
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  endtask

  task automatic wr(input logic [5:0] a, input logic [31:0] d);
    cfg_wr = 1'b1; cfg_addr = a; cfg_wdata = d;
    @(posedge clk); #1;
    cfg_wr = 1'b0;
  endtask

  task automatic rd(input logic [5:0] a, input logic [31:0] e, input string req);
    cfg_addr = a;
    @(negedge clk);
    chk(req, 64'(cfg_rdata), 64'(e));
    @(posedge clk); #1;
  endtask

  task automatic look(input logic [63:0] a, input bit d, input bit eh,
                      input logic [1:0] ei, input logic [63:0] el, input string req);
    lk_addr = a; lk_direct = d;
    @(negedge clk);
    chk(req, 64'(win_hit), 64'(eh));
    chk(req, 64'(win_idx), 64'(ei));
    chk(req, loc_addr, el);
    @(posedge clk); #1;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++; n_err++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    finish_run();
  end

  initial begin
    rst_n = 1'b0; cfg_wr = 1'b0; cfg_addr = '0; cfg_wdata = '0;
    lk_addr = '0; lk_direct = 1'b0;
    @(posedge clk); #1;
    chk_on = 1;
    // R1 reset state
    rd(6'h04, 32'hFFFF_FFFF, "R1 size hi");
    rd(6'h00, 32'h0, "R1 size lo");
    rd(6'h14, 32'hFFFF_FFFF, "R1 narrow size hi");
    rd(6'h2C, 32'h0, "R1 base hi");
    look(64'h0, 0, 0, 0, 64'h0, "R1 pass after reset");
    rst_n = 1'b1;
    @(posedge clk); #1;
    look(64'h10, 0, 0, 0, 64'h10, "R1 pass after release");

    // R2 disabled window
    wr(6'h08, 32'h3400_0000);
    wr(6'h0C, 32'h0000_0012);
    wr(6'h00, 32'hFFFF_F000);
    look(64'h100, 0, 0, 0, 64'h100, "R2 disabled");

    // R11 takes effect right after the write edge
    lk_addr = 64'h100;
    wr(6'h00, 32'hFFFF_F001);
    @(negedge clk);
    chk("R11 hit after write", 64'(win_hit), 64'd1);
    @(posedge clk); #1;

    // R3 / R4 range edges
    look(64'hFFF, 0, 1, 0, 64'h12_3400_0FFF, "R3 R4 last byte");
    look(64'h1000, 0, 0, 0, 64'h1000, "R3 first outside");
    wr(6'h00, 32'hFFFF_F007);
    look(64'h1000, 0, 0, 0, 64'h1000, "R3 low bits ignored");
    look(64'hFFF, 0, 1, 0, 64'h12_3400_0FFF, "R3 low bits ignored hit");

    // R5 priority
    wr(6'h28, 32'h0);
    wr(6'h2C, 32'h8000_0000);
    wr(6'h20, 32'hFFFF_0001);
    look(64'h2000, 0, 1, 2, 64'h8000_0000_0000_2000, "R5 only window 2");
    look(64'h800, 0, 1, 0, 64'h12_3400_0800, "R5 window 0 wins");

    // R6 direct decode outranks
    look(64'h800, 1, 0, 0, 64'h800, "R6 direct");

    // R9 narrow window
    wr(6'h10, 32'h0000_0001);
    rd(6'h14, 32'h0, "R9 high cleared");
    wr(6'h14, 32'h1234_5678);
    rd(6'h14, 32'h0, "R9 high ignored");
    wr(6'h00, 32'h0);
    look(64'h800, 0, 1, 1, 64'h800, "R5 window 1 over 2");
    look(64'hDEAD_BEEF_0000_0000, 0, 1, 1, 64'hDEAD_BEEF_0000_0000, "R3 zero mask full span");
    wr(6'h18, 32'hFFFF_FFF0);
    wr(6'h1C, 32'hFFFF_FFFF);
    look(64'h20, 0, 1, 1, 64'h10, "R4 wrap");

    // R10 unmapped
    wr(6'h30, 32'hFFFF_FFFF);
    wr(6'h3C, 32'hFFFF_FFFF);
    rd(6'h30, 32'h0, "R10 read zero");
    rd(6'h3C, 32'h0, "R10 read zero hi");
    rd(6'h18, 32'hFFFF_FFF0, "R10 no side effect");
    look(64'h20, 0, 1, 1, 64'h10, "R10 lookup unchanged");

    // R8 independent halves
    wr(6'h1C, 32'h0000_0001);
    rd(6'h18, 32'hFFFF_FFF0, "R8 low kept");
    rd(6'h1C, 32'h0000_0001, "R8 high written");

    // random phase, reference model compares every cycle
    for (int n = 0; n < 4000; n++) begin
      logic [31:0] d;
      int k;
      k = $urandom % 8;
      d = $urandom;
      if ($urandom % 2) d = ~((32'd1 << ($urandom % 32)) - 32'd1) | 32'($urandom % 2);
      if (k == 0) d = 32'hFFFF_FFFF;
      cfg_wr = (($urandom % 4) == 0);
      cfg_addr = 6'($urandom % 64) & 6'h3C;
      cfg_wdata = d;
      case ($urandom % 4)
        0: lk_addr = 64'($urandom % 32'h0010_0000);
        1: lk_addr = {$urandom, $urandom};
        2: lk_addr = 64'h1 << ($urandom % 64);
        default: lk_addr = (64'h1 << ($urandom % 40)) - 64'($urandom % 3);
      endcase
      lk_direct = (($urandom % 8) == 0);
      @(posedge clk); #1;
    end
    cfg_wr = 1'b0;
    @(posedge clk); #1;
    finish_run();
  end
endmodule